// File: doc/BRIEF.md
# Register-Match Debug Break Controller

This unit sits beside a small CPU and turns two debug conditions into a halt request. The first condition is that a watched register holds a programmed compare value. The second is that the CPU touched an undefined address region. The watched register is judged only at instruction boundaries, marked by a one-cycle strobe. The CPU has already started the following instruction by the time a judgment is made, so the halt takes effect one instruction late. It lands at the next instruction fetch after that following instruction has retired. The fetch address at that moment is captured as the break address.

An interrupt acknowledge cycle, signalled by an active-low input, cannot be stopped once it has begun. The controller therefore never raises the halt while acknowledge is low. A break that becomes due during an acknowledge is held back. It then fires on the first fetch made once acknowledge has returned high, which is the top of the interrupt handler. A host sets the compare value and the two enables through a single write strobe. It releases a halted CPU by pulsing the resume input.

Top module: `dbg_break_ctrl`

## Requirements
- R1: After reset, `halt_req` is 0, `brk_cause` is 2'b00 and `brk_addr` is 0. Both break sources are disabled, so no break can fire until the configuration is written.
- R2: The watched value is compared only in cycles where `insn_end` is 1. A value on `reg_val` that equals the compare value in any other cycle causes no break.
- R3: A break detected at a judgment point becomes due when the next `insn_end` arrives. It takes effect at the first `fetch_valid` cycle after that, with `iack_n` high. `halt_req` rises on the following cycle and `brk_addr` holds that cycle's `fetch_addr`. Before that point `halt_req` stays 0.
- R4: `halt_req` never rises from a cycle in which `iack_n` was 0.
- R5: A break detected while `iack_n` is 0 is due immediately. Fetches made while `iack_n` is 0 are skipped. The halt lands on the first fetch made after `iack_n` returns to 1, and its address is latched.
- R6: When the undefined-region break is enabled, an `undef_hit` pulse at any cycle of an instruction is judged at that instruction's `insn_end`. The resulting break follows the timing of R3. When the undefined-region break is disabled, `undef_hit` has no effect.
- R7: `brk_cause` reads 2'b01 for a register match and 2'b10 for an undefined-region access. When both occur at the same judgment point, the result is 2'b01.
- R8: `halt_req` stays 1 until `resume` is pulsed and is 0 on the cycle after the pulse. A resume pulse also discards a break that is pending but has not yet fired.
- R9: A match that occurs while a break is already pending or the CPU is halted does not queue a second break. After resume, no extra halt follows.
- R10: When the compare enable is 0, no register value causes a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Writes the three configuration fields below |
| cfg_cmp_val | input | DW | Compare value to load |
| cfg_cmp_en | input | 1 | Register-match break enable to load |
| cfg_undef_en | input | 1 | Undefined-region break enable to load |
| reg_val | input | DW | Current value of the watched register |
| insn_end | input | 1 | Instruction boundary strobe (judgment point) |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| fetch_addr | input | AW | CPU fetch address |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| undef_hit | input | 1 | Access to an undefined region this cycle |
| resume | input | 1 | Releases the halt and drops any pending break |
| halt_req | output | 1 | Halt request to the CPU |
| brk_cause | output | 2 | Cause of the last break |
| brk_addr | output | AW | Fetch address where the last halt took effect |

## Verification
The bench builds the controller with a 4-bit watched register and an 8-bit fetch address. With that width, compare values of zero and all-ones can be driven directly, alongside ordinary near-miss values that differ by one bit. The narrow address keeps each latched break address distinct and easy to predict, so an off-by-one fetch in the late-halt timing shows up as a wrong address. A short stand-in CPU sequence is used to place matches before, during and after an acknowledge cycle.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_REG   = 2'b01,
        CAUSE_UNDEF = 2'b10
    } brk_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DUE  = 2'b10,
        ST_HALT = 2'b11
    } brk_state_e;

    typedef struct packed {
        logic cmp_en;
        logic undef_en;
    } brk_flags_t;

    function automatic brk_cause_e pick_cause(input logic reg_match, input logic undef_seen);
        if (reg_match)       return CAUSE_REG;
        else if (undef_seen) return CAUSE_UNDEF;
        else                 return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
    import dbg_brk_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] cmp_val_in,
    input  brk_flags_t    flags_in,
    output logic [DW-1:0] cmp_val,
    output brk_flags_t    flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
            flags   <= '0;
        end else if (we) begin
            cmp_val <= cmp_val_in;
            flags   <= flags_in;
        end
    end
endmodule

// File: rtl/brk_judge.sv
module brk_judge
    import dbg_brk_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] cmp_val,
    input  brk_flags_t    flags,
    input  logic          insn_end,
    input  logic          undef_hit,
    output logic          hit,
    output brk_cause_e    hit_cause
);
    logic undef_seen_q;
    logic reg_match;
    logic undef_any;

    // Undefined access anywhere inside the current instruction is remembered
    always_ff @(posedge clk) begin
        if (rst)            undef_seen_q <= 1'b0;
        else if (insn_end)  undef_seen_q <= 1'b0;
        else if (undef_hit) undef_seen_q <= 1'b1;
    end

    always_comb begin
        reg_match = flags.cmp_en && (reg_val == cmp_val);
        undef_any = flags.undef_en && (undef_seen_q || undef_hit);
        hit       = insn_end && (reg_match || undef_any);
        hit_cause = pick_cause(reg_match, undef_any);
    end
endmodule

// File: rtl/brk_sequencer.sv
module brk_sequencer
    import dbg_brk_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  brk_cause_e    hit_cause,
    input  logic          insn_end,
    input  logic          iack_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          resume,
    output logic          halt,
    output brk_cause_e    cause,
    output logic [AW-1:0] addr
);
    brk_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cause   <= CAUSE_NONE;
            addr    <= '0;
        end else if (resume) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (hit) begin
                    cause   <= hit_cause;
                    // During acknowledge the next "instruction" is the acknowledge itself
                    state_q <= iack_n ? ST_WAIT : ST_DUE;
                end
                ST_WAIT: if (insn_end || !iack_n) state_q <= ST_DUE;
                ST_DUE:  if (fetch_valid && iack_n) begin
                    state_q <= ST_HALT;
                    addr    <= fetch_addr;
                end
                ST_HALT: state_q <= ST_HALT;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign halt = (state_q == ST_HALT);
endmodule

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
    import dbg_brk_pkg::*;
#(
    parameter int DW = 4,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_cmp_val,
    input  logic          cfg_cmp_en,
    input  logic          cfg_undef_en,
    input  logic [DW-1:0] reg_val,
    input  logic          insn_end,
    input  logic          iack_n,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_valid,
    input  logic          undef_hit,
    input  logic          resume,
    output logic          halt_req,
    output logic [1:0]    brk_cause,
    output logic [AW-1:0] brk_addr
);
    logic [DW-1:0] cmp_val;
    brk_flags_t    flags;
    brk_flags_t    flags_in;
    logic          hit;
    brk_cause_e    hit_cause;
    brk_cause_e    cause;

    assign flags_in = '{cmp_en: cfg_cmp_en, undef_en: cfg_undef_en};

    brk_cfg_regs #(.DW(DW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we),
        .cmp_val_in(cfg_cmp_val), .flags_in(flags_in),
        .cmp_val(cmp_val), .flags(flags)
    );

    brk_judge #(.DW(DW)) u_judge (
        .clk(clk), .rst(rst), .reg_val(reg_val), .cmp_val(cmp_val),
        .flags(flags), .insn_end(insn_end), .undef_hit(undef_hit),
        .hit(hit), .hit_cause(hit_cause)
    );

    brk_sequencer #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .hit(hit), .hit_cause(hit_cause),
        .insn_end(insn_end), .iack_n(iack_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .resume(resume),
        .halt(halt_req), .cause(cause), .addr(brk_addr)
    );

    assign brk_cause = cause;
endmodule

// File: rtl/dbg_break_ctrl_chk.sv
module dbg_break_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          iack_n,
    input logic          fetch_valid,
    input logic          resume,
    input logic          halt_req,
    input logic [1:0]    brk_cause,
    input logic [AW-1:0] brk_addr
);
    p_halt_needs_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req) |-> $past(fetch_valid));

    p_no_halt_in_iack_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req) |-> $past(iack_n));

    p_cause_valid_r7: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (brk_cause == 2'b01 || brk_cause == 2'b10));

    p_halt_held_r8: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !resume) |=> halt_req);

    p_resume_drops_r8: assert property (@(posedge clk) disable iff (rst)
        resume |=> !halt_req);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (halt_req && $past(halt_req)) |-> $stable(brk_addr));
endmodule

bind dbg_break_ctrl dbg_break_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .iack_n(iack_n), .fetch_valid(fetch_valid),
    .resume(resume), .halt_req(halt_req), .brk_cause(brk_cause),
    .brk_addr(brk_addr)
);

// File: tb/dbg_break_ctrl_bench.sv
module dbg_break_ctrl_bench;
    localparam int DW = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [DW-1:0] cfg_cmp_val = '0;
    logic          cfg_cmp_en = 1'b0;
    logic          cfg_undef_en = 1'b0;
    logic [DW-1:0] reg_val = '0;
    logic          insn_end = 1'b0;
    logic          iack_n = 1'b1;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_valid = 1'b0;
    logic          undef_hit = 1'b0;
    logic          resume = 1'b0;
    logic          halt_req;
    logic [1:0]    brk_cause;
    logic [AW-1:0] brk_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dbg_break_ctrl #(.DW(DW), .AW(AW)) u_dbg_break_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock with the given inputs, driven after a falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_ins();
        insn_end = 0; fetch_valid = 0; undef_hit = 0; resume = 0; cfg_we = 0;
    endtask

    task automatic insn(input logic [DW-1:0] rv, input logic und);
        reg_val = rv; undef_hit = und; insn_end = 1;
        step(); clear_ins();
    endtask

    task automatic fetch(input logic [AW-1:0] a);
        fetch_addr = a; fetch_valid = 1;
        step(); clear_ins();
    endtask

    task automatic do_resume();
        resume = 1; step(); clear_ins();
    endtask

    task automatic cfg(input logic [DW-1:0] v, input logic ce, input logic ue);
        cfg_cmp_val = v; cfg_cmp_en = ce; cfg_undef_en = ue; cfg_we = 1;
        step(); clear_ins();
    endtask

    // {cmp_en, cmp_val, reg_val, expect_halt}
    localparam int NV = 6;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 4'd5,  4'd5,  1'b1},
        {1'b1, 4'd5,  4'd4,  1'b0},
        {1'b1, 4'd0,  4'd0,  1'b1},
        {1'b1, 4'hF,  4'hF,  1'b1},
        {1'b1, 4'hF,  4'h7,  1'b0},
        {1'b0, 4'd9,  4'd9,  1'b0}
    };

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        step(); step();
        rst = 0;
        step();
        // R1: reset state, nothing armed even though reg_val equals cleared compare
        chk("R1 halt", halt_req, 0);
        chk("R1 cause", brk_cause, 0);
        chk("R1 addr", brk_addr, 0);
        fetch(8'h01); insn(4'd0, 1'b1); fetch(8'h02); insn(4'd0, 1'b1); fetch(8'h03);
        chk("R1 unarmed", halt_req, 0);

        // Table walk: R3 / R10 normal late-halt path
        for (int i = 0; i < NV; i++) begin
            do_resume();
            cfg(VEC[i][8:5], VEC[i][9], 1'b0);
            fetch(8'h10); insn(VEC[i][4:1], 1'b0);
            fetch(8'h11); insn(4'd6, 1'b0);
            chk("R3 not before next fetch", halt_req, 0);
            fetch(8'h12);
            chk(VEC[i][9] ? "R3 halt" : "R10 halt", halt_req, int'(VEC[i][0]));
            if (VEC[i][0]) begin
                chk("R7 reg cause", brk_cause, 1);
                chk("R3 addr", brk_addr, 8'h12);
            end
        end

        // R8: halt holds, resume drops it
        do_resume(); cfg(4'd5, 1'b1, 1'b0);
        fetch(8'h20); insn(4'd5, 1'b0); fetch(8'h21); insn(4'd6, 1'b0); fetch(8'h22);
        step(); step(); insn(4'd5, 1'b0);
        chk("R8 held", halt_req, 1);
        chk("R8 addr kept", brk_addr, 8'h22);
        do_resume();
        chk("R8 resume", halt_req, 0);
        // R9: matches during pending/halt queued nothing
        fetch(8'h23); insn(4'd1, 1'b0); fetch(8'h24); insn(4'd1, 1'b0); fetch(8'h25);
        chk("R9 no second", halt_req, 0);

        // R9: back-to-back matches give one break only
        fetch(8'h30); insn(4'd5, 1'b0); fetch(8'h31); insn(4'd5, 1'b0); fetch(8'h32);
        chk("R9 single halt", halt_req, 1);
        do_resume();
        fetch(8'h33); insn(4'd2, 1'b0); fetch(8'h34); insn(4'd2, 1'b0); fetch(8'h35);
        chk("R9 nothing after resume", halt_req, 0);

        // R8: resume clears a pending break
        fetch(8'h40); insn(4'd5, 1'b0); do_resume();
        fetch(8'h41); insn(4'd6, 1'b0); fetch(8'h42);
        chk("R8 pending dropped", halt_req, 0);

        // R2: match outside judgment point ignored
        reg_val = 4'd5; step(); step();
        fetch(8'h50); insn(4'd3, 1'b0); fetch(8'h51); insn(4'd3, 1'b0); fetch(8'h52);
        chk("R2 no judgment", halt_req, 0);

        // R4/R5: match while acknowledge low
        iack_n = 0;
        fetch(8'h60); insn(4'd5, 1'b0);
        fetch(8'h61);
        chk("R4 no halt in iack", halt_req, 0);
        iack_n = 1;
        fetch(8'h80);
        chk("R5 halt at handler", halt_req, 1);
        chk("R5 handler addr", brk_addr, 8'h80);
        do_resume();

        // R5: acknowledge starts during the late instruction
        fetch(8'h70); insn(4'd5, 1'b0);
        iack_n = 0; step(); fetch(8'h71);
        chk("R4 no halt in iack 2", halt_req, 0);
        iack_n = 1; fetch(8'h84);
        chk("R5 late iack addr", brk_addr, 8'h84);
        do_resume();

        // R6: undefined access break, mid-instruction pulse
        cfg(4'd5, 1'b0, 1'b1);
        fetch(8'h90); undef_hit = 1; step(); clear_ins(); insn(4'd5, 1'b0);
        fetch(8'h91); insn(4'd0, 1'b0);
        chk("R6 late", halt_req, 0);
        fetch(8'h92);
        chk("R6 halt", halt_req, 1);
        chk("R7 undef cause", brk_cause, 2);
        chk("R6 addr", brk_addr, 8'h92);
        do_resume();

        // R6: disabled undefined break ignored
        cfg(4'd5, 1'b0, 1'b0);
        fetch(8'hA0); insn(4'd5, 1'b1); fetch(8'hA1); insn(4'd5, 1'b1); fetch(8'hA2);
        chk("R6 disabled", halt_req, 0);

        // R7: both at same judgment point -> register match wins
        cfg(4'd5, 1'b1, 1'b1);
        fetch(8'hB0); insn(4'd5, 1'b1); fetch(8'hB1); insn(4'd0, 1'b0); fetch(8'hB2);
        chk("R7 halt", halt_req, 1);
        chk("R7 priority", brk_cause, 1);

        // R1: reset mid-halt
        rst = 1; step(); rst = 0; step();
        chk("R1 reset halt", halt_req, 0);
        chk("R1 reset cause", brk_cause, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule